// File: doc/BRIEF.md
# Indirect Branch Target Buffer

This block predicts where indirect jumps and indirect calls will go. It is a direct-mapped table indexed by the instruction pointer. The fetch stage presents a pointer on the lookup port and gets back, in the same cycle, a hit flag, a taken flag and a predicted target. An indirect branch is always taken, so every hit is predicted taken. On a miss the block makes no prediction and the front end falls through.

The execute stage reports each resolved branch on the resolve port. The report carries the branch's pointer, its actual target, an indirect flag and a call flag. The block compares the actual target with what the table holds for that pointer. Two cases count as a misprediction: a miss, and a hit whose stored target differs from the actual one. On a misprediction the block issues a single-cycle restart request that names the instruction and its correct target. A miss allocates a new entry. A wrong target deletes the entry instead of correcting it, so a branch whose target keeps changing mispredicts on every execution.

A saturating counter records how many mispredicted indirect calls have been resolved.

Top module: `indirect_target_buffer`

## Requirements
- R1: After a synchronous reset, every lookup misses, `flush_req` is 0 and `call_mispredicts` is 0.
- R2: Once an entry has been allocated for a pointer, a lookup of that pointer returns `fetch_hit`=1, `fetch_taken`=1 and the stored target on `fetch_target`.
- R3: A lookup hits only if the entry is valid and its tag matches. The index is `ip[IDX_W+1:2]` and the tag is the bits above it. A pointer with the same index but a different tag misses. On a miss, `fetch_hit`, `fetch_taken` and `fetch_target` are all 0.
- R4: An indirect resolve that hits with a matching target raises no restart, and the entry is kept.
- R5: An indirect resolve that misses allocates the entry and raises a restart. The restart is reported one clock later as `flush_req`=1 for exactly one cycle, with `flush_ip` set to the resolved pointer and `flush_target` set to the actual target.
- R6: An indirect resolve that hits with a different target raises the same restart as in R5 and deletes the entry, so the next lookup of that pointer misses.
- R7: A branch whose actual target alternates between two values mispredicts on every execution.
- R8: `call_mispredicts` rises by one, one clock after each mispredicted indirect resolve that has `res_is_call`=1. It does not change after any other resolve.
- R9: `call_mispredicts` saturates at all ones.
- R10: A resolve with `res_indirect`=0 changes neither the table, `flush_req` nor the counter.
- R11: When a lookup and an update hit the same index in the same cycle, the lookup returns the contents from before the update. The update is visible after the clock edge.
- R12: Pointer bits [1:0] take no part in the index or the tag, so pointers that differ only in those bits share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_ip | input | ADDR_W | Pointer presented for lookup |
| fetch_hit | output | 1 | Valid entry with a matching tag |
| fetch_taken | output | 1 | Predicted taken (same as hit for indirect branches) |
| fetch_target | output | ADDR_W | Predicted target, 0 on a miss |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_indirect | input | 1 | The resolved branch is indirect |
| res_is_call | input | 1 | The resolved branch is a near call |
| res_ip | input | ADDR_W | Pointer of the resolved branch |
| res_target | input | ADDR_W | Actual target of the resolved branch |
| flush_req | output | 1 | One-cycle restart request |
| flush_ip | output | ADDR_W | Pointer of the instruction to restart |
| flush_target | output | ADDR_W | Correct target for the restart |
| call_mispredicts | output | CNT_W | Saturating count of mispredicted indirect calls |

## Verification
The assertions check the per-cycle rules on every cycle:
- a restart only ever follows an indirect resolve;
- a miss gives no prediction and no taken flag;
- the counter never falls, holds once saturated, and moves only after an indirect call resolve;
- a deleted entry always comes with a restart.

Some behaviours depend on the table's contents over a sequence of operations, and only the bench's scenarios can show them:
- allocation and deletion across a run of resolves;
- tag aliasing between pointers that share an index;
- the misprediction on every execution of an alternating target;
- the old-contents result when a lookup and an update meet in the same cycle.

// File: rtl/itb_pkg.sv
package itb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_ALLOC = 2'd1,
    UPD_KILL  = 2'd2
  } upd_op_e;
endpackage

// File: rtl/itb_table.sv
module itb_table
  import itb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-3:0] rd_a_word,
  output logic              rd_a_hit,
  output logic [ADDR_W-1:0] rd_a_target,
  input  logic [ADDR_W-3:0] rd_b_word,
  output logic              rd_b_hit,
  output logic [ADDR_W-1:0] rd_b_target,
  input  upd_op_e           wr_op,
  input  logic [ADDR_W-3:0] wr_word,
  input  logic [ADDR_W-1:0] wr_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-3:0] w);
    return w[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-3:0] w);
    return w[ADDR_W-3:IDX_W];
  endfunction

  function automatic logic probe(input logic v, input logic [TAG_W-1:0] stored,
                                 input logic [ADDR_W-3:0] w);
    return v && (stored == tag_of(w));
  endfunction

  logic [IDX_W-1:0] a_slot, b_slot, w_slot;
  assign a_slot = slot_of(rd_a_word);
  assign b_slot = slot_of(rd_b_word);
  assign w_slot = slot_of(wr_word);

  always_comb begin
    rd_a_hit    = probe(valid_q[a_slot], tag_mem[a_slot], rd_a_word);
    rd_a_target = rd_a_hit ? tgt_mem[a_slot] : '0;
    rd_b_hit    = probe(valid_q[b_slot], tag_mem[b_slot], rd_b_word);
    rd_b_target = rd_b_hit ? tgt_mem[b_slot] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      case (wr_op)
        UPD_ALLOC: valid_q[w_slot] <= 1'b1;
        UPD_KILL:  valid_q[w_slot] <= 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_op == UPD_ALLOC) begin
      tag_mem[w_slot] <= tag_of(wr_word);
      tgt_mem[w_slot] <= wr_target;
    end
  end
endmodule

// File: rtl/itb_resolve.sv
module itb_resolve
  import itb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              res_valid,
  input  logic              res_indirect,
  input  logic              res_is_call,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              look_hit,
  input  logic [ADDR_W-1:0] look_target,
  output upd_op_e           wr_op,
  output logic              mispredict,
  output logic              call_mispredict
);
  function automatic logic wrong_target(input logic hit, input logic [ADDR_W-1:0] stored,
                                        input logic [ADDR_W-1:0] actual);
    return !hit || (stored != actual);
  endfunction

  logic active;
  assign active = res_valid && res_indirect;

  always_comb begin
    mispredict      = active && wrong_target(look_hit, look_target, res_target);
    call_mispredict = mispredict && res_is_call;
    if (!active)       wr_op = UPD_NONE;
    else if (!look_hit) wr_op = UPD_ALLOC;
    else if (mispredict) wr_op = UPD_KILL;
    else               wr_op = UPD_NONE;
  end
endmodule

// File: rtl/itb_perf_cnt.sv
module itb_perf_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= sat_inc(count);
  end
endmodule

// File: rtl/indirect_target_buffer.sv
module indirect_target_buffer
  import itb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_ip,
  output logic              fetch_hit,
  output logic              fetch_taken,
  output logic [ADDR_W-1:0] fetch_target,
  input  logic              res_valid,
  input  logic              res_indirect,
  input  logic              res_is_call,
  input  logic [ADDR_W-1:0] res_ip,
  input  logic [ADDR_W-1:0] res_target,
  output logic              flush_req,
  output logic [ADDR_W-1:0] flush_ip,
  output logic [ADDR_W-1:0] flush_target,
  output logic [CNT_W-1:0]  call_mispredicts
);
  // Named internal events, used by the bound checker.
  logic              res_hit;
  logic [ADDR_W-1:0] res_stored;
  upd_op_e           upd_op;
  logic              mispredict_ev;
  logic              call_mp_ev;
  logic              alloc_ev;
  logic              kill_ev;

  itb_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_a_word  (fetch_ip[ADDR_W-1:2]),
    .rd_a_hit   (fetch_hit),
    .rd_a_target(fetch_target),
    .rd_b_word  (res_ip[ADDR_W-1:2]),
    .rd_b_hit   (res_hit),
    .rd_b_target(res_stored),
    .wr_op      (upd_op),
    .wr_word    (res_ip[ADDR_W-1:2]),
    .wr_target  (res_target)
  );

  assign fetch_taken = fetch_hit;

  itb_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .res_valid      (res_valid),
    .res_indirect   (res_indirect),
    .res_is_call    (res_is_call),
    .res_target     (res_target),
    .look_hit       (res_hit),
    .look_target    (res_stored),
    .wr_op          (upd_op),
    .mispredict     (mispredict_ev),
    .call_mispredict(call_mp_ev)
  );

  assign alloc_ev = (upd_op == UPD_ALLOC);
  assign kill_ev  = (upd_op == UPD_KILL);

  itb_perf_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .bump (call_mp_ev),
    .count(call_mispredicts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req    <= 1'b0;
      flush_ip     <= '0;
      flush_target <= '0;
    end else begin
      flush_req <= mispredict_ev;
      if (mispredict_ev) begin
        flush_ip     <= res_ip;
        flush_target <= res_target;
      end
    end
  end
endmodule

// File: rtl/indirect_target_buffer_chk.sv
module indirect_target_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_hit,
  input logic              fetch_taken,
  input logic [ADDR_W-1:0] fetch_target,
  input logic              res_valid,
  input logic              res_indirect,
  input logic              res_is_call,
  input logic              flush_req,
  input logic [CNT_W-1:0]  call_mispredicts,
  input logic              kill_ev
);
  assert_flush_cause_R5: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_indirect) |=> !flush_req);

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !fetch_hit |-> (!fetch_taken && fetch_target == '0));

  assert_hit_taken_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> fetch_taken);

  assert_kill_flush_R6: assert property (@(posedge clk) disable iff (rst)
    kill_ev |=> flush_req);

  assert_cnt_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> call_mispredicts >= $past(call_mispredicts));

  assert_cnt_only_calls_R8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_indirect && res_is_call) |=> $stable(call_mispredicts));

  assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (&call_mispredicts) |=> (&call_mispredicts));
endmodule

bind indirect_target_buffer indirect_target_buffer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .fetch_hit       (fetch_hit),
  .fetch_taken     (fetch_taken),
  .fetch_target    (fetch_target),
  .res_valid       (res_valid),
  .res_indirect    (res_indirect),
  .res_is_call     (res_is_call),
  .flush_req       (flush_req),
  .call_mispredicts(call_mispredicts),
  .kill_ev         (kill_ev)
);

// File: tb/test_indirect_target_buffer.sv
module test_indirect_target_buffer;
  localparam int AW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_ip = '0;
  logic          fetch_hit, fetch_taken;
  logic [AW-1:0] fetch_target;
  logic          res_valid = 1'b0, res_indirect = 1'b0, res_is_call = 1'b0;
  logic [AW-1:0] res_ip = '0, res_target = '0;
  logic          flush_req;
  logic [AW-1:0] flush_ip, flush_target;
  logic [CW-1:0] call_mispredicts;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  indirect_target_buffer #(.ENTRIES(64), .ADDR_W(AW), .CNT_W(CW)) i_indirect_target_buffer (
    .clk(clk), .rst(rst), .fetch_ip(fetch_ip), .fetch_hit(fetch_hit),
    .fetch_taken(fetch_taken), .fetch_target(fetch_target),
    .res_valid(res_valid), .res_indirect(res_indirect), .res_is_call(res_is_call),
    .res_ip(res_ip), .res_target(res_target), .flush_req(flush_req),
    .flush_ip(flush_ip), .flush_target(flush_target),
    .call_mispredicts(call_mispredicts)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] ip, input bit hit, input logic [AW-1:0] tgt,
                      input string req);
    fetch_ip = ip;
    #1;
    chk(fetch_hit == hit, req, "fetch_hit", {31'b0, fetch_hit}, {31'b0, hit});
    chk(fetch_taken == hit, req, "fetch_taken", {31'b0, fetch_taken}, {31'b0, hit});
    chk(fetch_target == (hit ? tgt : '0), req, "fetch_target", fetch_target, hit ? tgt : '0);
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic resolve(input logic [AW-1:0] ip, input logic [AW-1:0] tgt,
                         input bit ind, input bit call, input bit exp_flush, input string req);
    res_valid = 1'b1; res_indirect = ind; res_is_call = call;
    res_ip = ip; res_target = tgt;
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    if (exp_flush && call && exp_cnt < 15) exp_cnt++;
    chk(flush_req == exp_flush, req, "flush_req", {31'b0, flush_req}, {31'b0, exp_flush});
    if (exp_flush) begin
      chk(flush_ip == ip, req, "flush_ip", flush_ip, ip);
      chk(flush_target == tgt, req, "flush_target", flush_target, tgt);
    end
    chk(call_mispredicts == exp_cnt[CW-1:0], req, "call_mispredicts",
        {28'b0, call_mispredicts}, exp_cnt);
  endtask

  task automatic t_reset;
    look(32'h0000_1000, 0, 0, "R1");
    look(32'h0000_0000, 0, 0, "R1");
    chk(flush_req == 0, "R1", "flush_req", {31'b0, flush_req}, 0);
    chk(call_mispredicts == 0, "R1", "count", {28'b0, call_mispredicts}, 0);
  endtask

  task automatic t_alloc;
    resolve(32'h0000_1000, 32'h0000_2000, 1, 0, 1, "R5");
    @(posedge clk); @(negedge clk);
    chk(flush_req == 0, "R5", "flush_req one cycle", {31'b0, flush_req}, 0);
    look(32'h0000_1000, 1, 32'h0000_2000, "R2");
    look(32'h0000_1003, 1, 32'h0000_2000, "R12");
    look(32'h0000_1100, 0, 0, "R3");
  endtask

  task automatic t_correct;
    resolve(32'h0000_1000, 32'h0000_2000, 1, 1, 0, "R4");
    look(32'h0000_1000, 1, 32'h0000_2000, "R4");
  endtask

  task automatic t_mismatch;
    resolve(32'h0000_1000, 32'h0000_3000, 1, 1, 1, "R6");
    look(32'h0000_1000, 0, 0, "R6");
  endtask

  task automatic t_alternate;
    for (int k = 0; k < 4; k++)
      resolve(32'h0000_4008, (k % 2 == 0) ? 32'h0000_A000 : 32'h0000_B000, 1, 1, 1, "R7");
    look(32'h0000_4008, 0, 0, "R7");
  endtask

  task automatic t_non_indirect;
    resolve(32'h0000_5000, 32'h0000_6000, 1, 0, 1, "R10");
    resolve(32'h0000_5000, 32'h0000_7000, 0, 1, 0, "R10");
    look(32'h0000_5000, 1, 32'h0000_6000, "R10");
    resolve(32'h0000_5400, 32'h0000_7000, 0, 1, 0, "R10");
    look(32'h0000_5400, 0, 0, "R10");
  endtask

  task automatic t_same_cycle;
    fetch_ip = 32'h0000_5000;
    res_valid = 1'b1; res_indirect = 1'b1; res_is_call = 1'b0;
    res_ip = 32'h0000_5000; res_target = 32'h0000_9000;
    #1;
    chk(fetch_hit == 1 && fetch_target == 32'h0000_6000, "R11", "old contents",
        fetch_target, 32'h0000_6000);
    @(posedge clk); @(negedge clk);
    res_valid = 1'b0;
    chk(flush_req == 1, "R11", "flush_req", {31'b0, flush_req}, 1);
    look(32'h0000_5000, 0, 0, "R11");
    fetch_ip = 32'h0000_5800;
    res_valid = 1'b1; res_ip = 32'h0000_5800; res_target = 32'h0000_C000;
    #1;
    chk(fetch_hit == 0, "R11", "miss before alloc", {31'b0, fetch_hit}, 0);
    @(posedge clk); @(negedge clk);
    res_valid = 1'b0;
    look(32'h0000_5800, 1, 32'h0000_C000, "R11");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 14; k++)
      resolve(32'h0000_8000 + 32'(k * 4), 32'h0000_D000, 1, 1, 1, "R9");
    chk(call_mispredicts == 4'hF, "R9", "saturated", {28'b0, call_mispredicts}, 32'hF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alloc();
        t_correct();
        t_mismatch();
        t_alternate();
        t_non_indirect();
        t_same_cycle();
        t_saturate();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule